// File: doc/BRIEF.md
# Two-Way Byte-Tracked Mailbox Exchange

This block carries short messages between two register buses, called side A and side B, that share one clock. Each direction has its own four-byte mailbox: side A fills the outbound one and side B drains it, and the return mailbox works the other way round. A full/empty flag is kept for every byte rather than every word. A narrow agent can therefore hand over one byte at a time, and the receiver can see exactly which lanes hold fresh data.

Both sides can read a shared status word. It reports the per-byte flags and two sticky bits that record lost data. Each side owns a small interrupt setup that names one incoming byte lane. While that lane is full and the setup is enabled, the side's interrupt line is held high. A separate hardware strobe deposits a whole word into the B-to-A mailbox in one cycle, without any bus access. The deposit marks all four lanes full and therefore wakes side A's interrupt if that is enabled.

Each side has the same four-register window, selected by a 2-bit address: 0 is the own outbound mailbox, 1 is the incoming mailbox, 2 is the shared status, and 3 is the interrupt setup.

Top module: `mbox_pair_top`

## Requirements
- R1: After reset every byte flag, both loss bits and both interrupt setups read as zero, and irq_a and irq_b are low.
- R2: A write to address 0 stores the data of each enabled byte lane into that side's outbound mailbox and sets the flags of those lanes. Lanes that are not enabled keep their data and flags. A later read of address 0 returns the stored outbound word.
- R3: A read of address 1 returns the whole incoming mailbox word and clears the flags of the enabled lanes only.
- R4: When the sender writes a lane in the same cycle that the receiver reads it, the flag stays set, the read returns the old byte, and the new byte is kept.
- R5: The status word at address 2 holds the A-to-B flags in bits 3:0 and the B-to-A flags in bits 7:4, with bit n for byte n. Bit 8 is the A-to-B loss bit, bit 9 is the B-to-A loss bit, and all higher bits are zero.
- R6: A write to a lane that is full and is not being read in the same cycle replaces the byte and sets that direction's loss bit. The loss bit stays set until either side writes address 2 with lane 1 enabled and a 1 in the bit's position. A new loss in that same cycle wins over the clear.
- R7: A cycle with hw_load_stb high writes hw_load_data into all four B-to-A lanes and sets all four flags. It takes priority over a side-B write to address 0 in the same cycle.
- R8: Address 3 holds the interrupt setup: bits 1:0 select an incoming lane, written with lane 0 enabled, and bit 8 enables the interrupt, written with lane 1 enabled. irq_a is high exactly while side A's setup is enabled and the selected B-to-A lane is full. irq_b behaves the same way with side B's setup and the A-to-B lanes.
- R9: Read data appears on the rdata port in the cycle after the read request. It holds that value until the next read on the same side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A write request |
| a_rd_en | input | 1 | Side A read request |
| a_addr | input | 2 | Side A register select |
| a_be | input | 4 | Side A byte lane enables |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, registered |
| b_wr_en | input | 1 | Side B write request |
| b_rd_en | input | 1 | Side B read request |
| b_addr | input | 2 | Side B register select |
| b_be | input | 4 | Side B byte lane enables |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, registered |
| hw_load_stb | input | 1 | Hardware deposit strobe into the B-to-A mailbox |
| hw_load_data | input | 32 | Word taken by the hardware deposit |
| irq_a | output | 1 | Level interrupt toward side A |
| irq_b | output | 1 | Level interrupt toward side B |

## Verification
Flags, stored data, loss bits and the interrupt setups all change on the clock edge that takes the request. The interrupt lines are decoded straight from those registers, so a new irq level is due just after that same edge. Read data is registered and is due just after the edge that takes the read, and it reflects the state from before that edge. The bench therefore works out the expected read word from its model before the edge, updates the model at the edge, and compares rdata and both interrupt lines one nanosecond after the edge. It also waits out the two-cycle reset synchronizer before it issues any request.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_NB     = 4;
  localparam int MB_BYTE_W = 8;
  localparam int MB_ADDR_W = 2;

  typedef enum logic [MB_ADDR_W-1:0] {
    REG_TX   = 2'd0,
    REG_RX   = 2'd1,
    REG_STAT = 2'd2,
    REG_CFG  = 2'd3
  } mb_reg_e;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int NB     = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = NB * BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [NB-1:0] wr_be,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stb,
  input  logic [NB-1:0] rd_be,
  input  logic          loss_clr,
  output logic [DW-1:0] data_o,
  output logic [NB-1:0] full_o,
  output logic          loss_o
);
  logic [NB-1:0]     set_v, clr_v, lost_v;
  logic [NB-1:0]     full_q, full_d;
  logic              loss_q, loss_d;
  logic [BYTE_W-1:0] lane_q [NB];

  always_comb begin
    set_v  = {NB{wr_stb}} & wr_be;
    clr_v  = {NB{rd_stb}} & rd_be;
    lost_v = set_v & full_q & ~clr_v;
    full_d = set_v | (full_q & ~clr_v);
    loss_d = (|lost_v) | (loss_q & ~loss_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      loss_q <= 1'b0;
    end else begin
      full_q <= full_d;
      loss_q <= loss_d;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane_q[g] <= '0;
      else if (set_v[g]) lane_q[g] <= wr_data[g*BYTE_W +: BYTE_W];
    end
    assign data_o[g*BYTE_W +: BYTE_W] = lane_q[g];

    // R2: a write to a lane marks it full on the next cycle
    p_set_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_be[g]) |=> full_o[g]);
    // R3: a read without a competing write empties the lane
    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_be[g] && !(wr_stb && wr_be[g])) |=> !full_o[g]);
    // R2: lanes not written keep their byte
    p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && wr_be[g]) |=> $stable(lane_q[g]));
  end

  assign full_o = full_q;
  assign loss_o = loss_q;

  // R6: loss bit is sticky until an explicit clear
  p_loss_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_o && !loss_clr) |=> loss_o);
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = NB * BYTE_W,
  localparam int SEL_W = $clog2(NB),
  localparam int STAT_W = 2 * NB + 2,
  localparam int LOSS_LANE = (2 * NB) / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [MB_ADDR_W-1:0] addr,
  input  logic [NB-1:0]        be,
  input  logic [DW-1:0]        wdata,
  input  logic [DW-1:0]        own_tx_data,
  input  logic [DW-1:0]        rx_data,
  input  logic [STAT_W-1:0]    status,
  output logic                 tx_wr,
  output logic                 rx_rd,
  output logic [1:0]           loss_clr,
  output logic [SEL_W-1:0]     irq_sel,
  output logic                 irq_en,
  output logic [DW-1:0]        rdata
);
  mb_reg_e          rsel;
  logic             stat_wr, cfg_wr;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             en_q, en_d;
  logic [DW-1:0]    rdata_q, rdata_d;

  assign rsel    = mb_reg_e'(addr);
  assign tx_wr   = wr_en && (rsel == REG_TX);
  assign rx_rd   = rd_en && (rsel == REG_RX);
  assign stat_wr = wr_en && (rsel == REG_STAT) && be[LOSS_LANE];
  assign cfg_wr  = wr_en && (rsel == REG_CFG);
  assign loss_clr[0] = stat_wr && wdata[2*NB];
  assign loss_clr[1] = stat_wr && wdata[2*NB+1];

  always_comb begin
    sel_d = sel_q;
    en_d  = en_q;
    if (cfg_wr && be[0]) sel_d = wdata[SEL_W-1:0];
    if (cfg_wr && be[1]) en_d  = wdata[BYTE_W];
  end

  always_comb begin
    unique case (rsel)
      REG_TX:   rdata_d = own_tx_data;
      REG_RX:   rdata_d = rx_data;
      REG_STAT: rdata_d = {{(DW-STAT_W){1'b0}}, status};
      REG_CFG:  rdata_d = {{(DW-BYTE_W-1){1'b0}}, en_q,
                           {(BYTE_W-SEL_W){1'b0}}, sel_q};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      en_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      sel_q <= sel_d;
      en_q  <= en_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign irq_sel = sel_q;
  assign irq_en  = en_q;
  assign rdata   = rdata_q;

  // R9: read data holds while no read is requested
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R8: setup fields change only through a setup write
  p_cfg_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(irq_sel) && $stable(irq_en)));
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int NB     = 4,
  localparam int SEL_W = $clog2(NB)
) (
  input  logic [NB-1:0]    full_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic             irq_o
);
  always_comb irq_o = en_i && full_i[sel_i];
endmodule

// File: rtl/mbox_pair_top.sv
module mbox_pair_top
  import mbox_pkg::*;
#(
  parameter int NB     = MB_NB,
  parameter int BYTE_W = MB_BYTE_W,
  localparam int DW    = NB * BYTE_W,
  localparam int SEL_W = $clog2(NB),
  localparam int STAT_W = 2 * NB + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 a_wr_en,
  input  logic                 a_rd_en,
  input  logic [MB_ADDR_W-1:0] a_addr,
  input  logic [NB-1:0]        a_be,
  input  logic [DW-1:0]        a_wdata,
  output logic [DW-1:0]        a_rdata,
  input  logic                 b_wr_en,
  input  logic                 b_rd_en,
  input  logic [MB_ADDR_W-1:0] b_addr,
  input  logic [NB-1:0]        b_be,
  input  logic [DW-1:0]        b_wdata,
  output logic [DW-1:0]        b_rdata,
  input  logic                 hw_load_stb,
  input  logic [DW-1:0]        hw_load_data,
  output logic                 irq_a,
  output logic                 irq_b
);
  logic             rst_s;
  logic             a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [1:0]       a_loss_clr, b_loss_clr;
  logic [SEL_W-1:0] a_sel, b_sel;
  logic             a_en, b_en;
  logic [DW-1:0]    a2b_data, b2a_data, b2a_wdata;
  logic [NB-1:0]    a2b_full, b2a_full, b2a_wbe;
  logic             a2b_loss, b2a_loss, b2a_wr;
  logic [STAT_W-1:0] status;

  mbox_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  // hardware deposit overrides a same-cycle side-B outbound write
  assign b2a_wr    = hw_load_stb || b_tx_wr;
  assign b2a_wbe   = hw_load_stb ? {NB{1'b1}} : b_be;
  assign b2a_wdata = hw_load_stb ? hw_load_data : b_wdata;
  assign status    = {b2a_loss, a2b_loss, b2a_full, a2b_full};

  mbox_channel #(.NB(NB), .BYTE_W(BYTE_W)) u_a2b (
    .clk(clk), .rst_n(rst_s),
    .wr_stb(a_tx_wr), .wr_be(a_be), .wr_data(a_wdata),
    .rd_stb(b_rx_rd), .rd_be(b_be),
    .loss_clr(a_loss_clr[0] || b_loss_clr[0]),
    .data_o(a2b_data), .full_o(a2b_full), .loss_o(a2b_loss));

  mbox_channel #(.NB(NB), .BYTE_W(BYTE_W)) u_b2a (
    .clk(clk), .rst_n(rst_s),
    .wr_stb(b2a_wr), .wr_be(b2a_wbe), .wr_data(b2a_wdata),
    .rd_stb(a_rx_rd), .rd_be(a_be),
    .loss_clr(a_loss_clr[1] || b_loss_clr[1]),
    .data_o(b2a_data), .full_o(b2a_full), .loss_o(b2a_loss));

  mbox_port #(.NB(NB), .BYTE_W(BYTE_W)) u_port_a (
    .clk(clk), .rst_n(rst_s),
    .wr_en(a_wr_en), .rd_en(a_rd_en), .addr(a_addr), .be(a_be), .wdata(a_wdata),
    .own_tx_data(a2b_data), .rx_data(b2a_data), .status(status),
    .tx_wr(a_tx_wr), .rx_rd(a_rx_rd), .loss_clr(a_loss_clr),
    .irq_sel(a_sel), .irq_en(a_en), .rdata(a_rdata));

  mbox_port #(.NB(NB), .BYTE_W(BYTE_W)) u_port_b (
    .clk(clk), .rst_n(rst_s),
    .wr_en(b_wr_en), .rd_en(b_rd_en), .addr(b_addr), .be(b_be), .wdata(b_wdata),
    .own_tx_data(b2a_data), .rx_data(a2b_data), .status(status),
    .tx_wr(b_tx_wr), .rx_rd(b_rx_rd), .loss_clr(b_loss_clr),
    .irq_sel(b_sel), .irq_en(b_en), .rdata(b_rdata));

  mbox_irq #(.NB(NB)) u_irq_a (.full_i(b2a_full), .sel_i(a_sel), .en_i(a_en), .irq_o(irq_a));
  mbox_irq #(.NB(NB)) u_irq_b (.full_i(a2b_full), .sel_i(b_sel), .en_i(b_en), .irq_o(irq_b));

  // R7: a deposit fills every lane with the strobed word
  p_hwload_fill_r7: assert property (@(posedge clk) disable iff (!rst_s)
    hw_load_stb |=> ((&b2a_full) && (b2a_data == $past(hw_load_data))));
  // R8: draining the selected lane drops irq_a unless refilled or reselected
  p_irq_a_drop_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_a && a_rx_rd && a_be[a_sel] && !(b2a_wr && b2a_wbe[a_sel]))
    |=> (!irq_a || (a_sel != $past(a_sel))));
  // R8: irq_b rises only after side A wrote a lane or side B changed setup
  p_irq_b_cause_r8: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(irq_b) |-> ($past(a_tx_wr) || $past(b_wr_en)));
endmodule

// File: tb/tb_mbox_pair_top.sv
`timescale 1ns/1ps
module tb_mbox_pair_top;
  logic        clk, rst_n;
  logic        a_wr_en, a_rd_en, b_wr_en, b_rd_en, hw_load_stb;
  logic [1:0]  a_addr, b_addr;
  logic [3:0]  a_be, b_be;
  logic [31:0] a_wdata, b_wdata, hw_load_data, a_rdata, b_rdata;
  logic        irq_a, irq_b;

  mbox_pair_top dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_ab_d, m_ba_d;
  logic [3:0]  m_ab_f, m_ba_f;
  logic [1:0]  m_loss;
  logic [1:0]  m_sel_a, m_sel_b;
  logic        m_en_a, m_en_b;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(bit side_b, logic [1:0] ad);
    case (ad)
      2'd0: return side_b ? m_ba_d : m_ab_d;
      2'd1: return side_b ? m_ab_d : m_ba_d;
      2'd2: return {22'd0, m_loss, m_ba_f, m_ab_f};
      default: return side_b ? {23'd0, m_en_b, 6'd0, m_sel_b}
                             : {23'd0, m_en_a, 6'd0, m_sel_a};
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] ad);
    case (ad)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  task automatic update_model();
    logic [3:0]  ab_set, ba_set, ab_clr, ba_clr;
    logic [31:0] ba_wd;
    logic        c0, c1;
    ab_set = (a_wr_en && a_addr == 2'd0) ? a_be : 4'd0;
    ba_set = hw_load_stb ? 4'hF : ((b_wr_en && b_addr == 2'd0) ? b_be : 4'd0);
    ba_wd  = hw_load_stb ? hw_load_data : b_wdata;
    ab_clr = (b_rd_en && b_addr == 2'd1) ? b_be : 4'd0;
    ba_clr = (a_rd_en && a_addr == 2'd1) ? a_be : 4'd0;
    c0 = (a_wr_en && a_addr == 2'd2 && a_be[1] && a_wdata[8]) ||
         (b_wr_en && b_addr == 2'd2 && b_be[1] && b_wdata[8]);
    c1 = (a_wr_en && a_addr == 2'd2 && a_be[1] && a_wdata[9]) ||
         (b_wr_en && b_addr == 2'd2 && b_be[1] && b_wdata[9]);
    m_loss[0] = (|(ab_set & m_ab_f & ~ab_clr)) || (m_loss[0] && !c0);
    m_loss[1] = (|(ba_set & m_ba_f & ~ba_clr)) || (m_loss[1] && !c1);
    m_ab_f = ab_set | (m_ab_f & ~ab_clr);
    m_ba_f = ba_set | (m_ba_f & ~ba_clr);
    m_ab_d = merge(m_ab_d, a_wdata, ab_set);
    m_ba_d = merge(m_ba_d, ba_wd, ba_set);
    if (a_wr_en && a_addr == 2'd3) begin
      if (a_be[0]) m_sel_a = a_wdata[1:0];
      if (a_be[1]) m_en_a  = a_wdata[8];
    end
    if (b_wr_en && b_addr == 2'd3) begin
      if (b_be[0]) m_sel_b = b_wdata[1:0];
      if (b_be[1]) m_en_b  = b_wdata[8];
    end
  endtask

  task automatic idle_inputs();
    a_wr_en = 0; a_rd_en = 0; a_addr = 0; a_be = 0; a_wdata = 0;
    b_wr_en = 0; b_rd_en = 0; b_addr = 0; b_be = 0; b_wdata = 0;
    hw_load_stb = 0; hw_load_data = 0;
  endtask

  // one clock: expected reads from pre-edge model, compare 1 ns after edge
  task automatic cycle();
    logic [31:0] ea, eb;
    bit ra, rb;
    ra = a_rd_en; rb = b_rd_en;
    ea = exp_read(0, a_addr); eb = exp_read(1, b_addr);
    if (ra) $display("  A read addr %0d (%s)", a_addr, tag_of(a_addr));
    @(posedge clk);
    update_model();
    #1;
    if (ra) check(tag_of(a_addr), a_rdata, ea);   // R9 latency
    if (rb) check(tag_of(b_addr), b_rdata, eb);
    check("R8 irq_a", {31'd0, irq_a}, {31'd0, m_en_a && m_ba_f[m_sel_a]});
    check("R8 irq_b", {31'd0, irq_b}, {31'd0, m_en_b && m_ab_f[m_sel_b]});
    idle_inputs();
  endtask

  task automatic a_op(bit w, logic [1:0] ad, logic [3:0] be, logic [31:0] d);
    a_wr_en = w; a_rd_en = !w; a_addr = ad; a_be = be; a_wdata = d;
  endtask
  task automatic b_op(bit w, logic [1:0] ad, logic [3:0] be, logic [31:0] d);
    b_wr_en = w; b_rd_en = !w; b_addr = ad; b_be = be; b_wdata = d;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_2024));
    m_ab_d = 0; m_ba_d = 0; m_ab_f = 0; m_ba_f = 0; m_loss = 0;
    m_sel_a = 0; m_sel_b = 0; m_en_a = 0; m_en_b = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R1: reset state through status and setup reads
    a_op(0, 2'd2, 4'hF, 0); b_op(0, 2'd3, 4'hF, 0); cycle();
    check("R1 status", a_rdata, 32'd0);
    check("R1 cfg", b_rdata, 32'd0);
    check("R1 irqs", {30'd0, irq_a, irq_b}, 32'd0);

    // R2: single lane write, only byte 2 flagged
    a_op(1, 2'd0, 4'b0100, 32'hAABBCCDD); cycle();
    b_op(0, 2'd2, 4'hF, 0); cycle();
    check("R2 lane flag", b_rdata, 32'h0000_0004);

    // R8: side B selects lane 2 and enables, irq_b goes high
    b_op(1, 2'd3, 4'b0011, 32'h0000_0102); cycle();
    check("R8 irq_b high", {31'd0, irq_b}, 32'd1);

    // R4: same-cycle write and read of lane 2
    a_op(1, 2'd0, 4'b0100, 32'h0011_0000); b_op(0, 2'd1, 4'b0100, 0); cycle();
    check("R4 old byte", b_rdata, 32'h00BB_0000);
    check("R4 flag kept", {31'd0, irq_b}, 32'd1);

    // R3: read drains lane 2, irq_b drops
    b_op(0, 2'd1, 4'b0100, 0); cycle();
    check("R3 new byte", b_rdata, 32'h0011_0000);
    check("R3 irq drop", {31'd0, irq_b}, 32'd0);

    // R9: rdata holds with no read
    held = b_rdata; cycle();
    check("R9 hold", b_rdata, held);

    // R7: hardware deposit beats a side-B write, R8 irq_a on lane 3
    a_op(1, 2'd3, 4'b0011, 32'h0000_0103); cycle();
    hw_load_stb = 1; hw_load_data = 32'h1234_5678; b_op(1, 2'd0, 4'hF, 32'hFFFF_FFFF); cycle();
    check("R7 irq_a", {31'd0, irq_a}, 32'd1);
    a_op(0, 2'd2, 4'hF, 0); cycle();
    check("R7 flags", a_rdata, 32'h0000_00F0);

    // R6: overflow by a second deposit, then clear
    hw_load_stb = 1; hw_load_data = 32'h8765_4321; cycle();
    a_op(0, 2'd1, 4'hF, 0); cycle();
    check("R6 overwrite", a_rdata, 32'h8765_4321);
    b_op(0, 2'd2, 4'hF, 0); cycle();
    check("R6 loss set", b_rdata, 32'h0000_0200);
    b_op(1, 2'd2, 4'b0010, 32'h0000_0200); cycle();
    a_op(0, 2'd2, 4'hF, 0); cycle();
    check("R6 loss clear", a_rdata, 32'd0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      a_op($urandom_range(0, 1), 2'($urandom), 4'($urandom), $urandom);
      b_op($urandom_range(0, 1), 2'($urandom), 4'($urandom), $urandom);
      if ($urandom_range(0, 3) == 0) begin a_wr_en = 0; a_rd_en = 0; end
      if ($urandom_range(0, 3) == 0) begin b_wr_en = 0; b_rd_en = 0; end
      if ($urandom_range(0, 9) == 0) begin hw_load_stb = 1; hw_load_data = $urandom; end
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule